// File: doc/BRIEF.md
# Multi-mode encoder phase counter

This block turns the edges of incremental encoder signals into position counts. It has two 16-bit counting channels. Each channel watches one pair of phase inputs and decodes them in one of three ways: full-resolution quadrature, where every edge of either phase counts; step plus direction, where a rising step edge counts and the direction level picks up or down; and half-resolution quadrature, where only edges of the second phase count. The decode is chosen per channel through a small mode field. All four encoder inputs pass through a two-stage synchronizer before any edge is seen.

Each channel has a ceiling register. An up-count from the ceiling clears the count to zero, and a down-count from zero reloads the ceiling. A shared control register can join the two channels into one 32-bit counter with a 32-bit ceiling, driven by the first channel's decode. The same register picks which input pair feeds the second channel. Software reads and writes modes, counts and ceilings through a flat register port. A per-channel status register shows the direction of the last count.

Top module: `phase_count_unit`

## Requirements
- R1: After reset both counts read 0, both ceilings read 0xFFFF, both mode fields read 4, the shared control register reads 0 and both status registers read 0x80.
- R2: Register addresses are: 0 mode of channel 1, 1 mode of channel 2, 2 shared control, 3 count 1, 4 count 2, 5 ceiling 1, 6 ceiling 2, 7 status 1, 8 status 2. A write takes effect on the next clock edge and a read is combinational. Mode registers keep only wdata[3:0]. Shared control keeps bit 0 (join) and bit 1 (pair select). Status registers are read-only.
- R3: In mode 4 (full quadrature), each single-phase edge on the first input X or the second input Y counts once. An X edge counts up when the new X differs from Y. A Y edge counts up when the new Y equals X. Otherwise the edge counts down. A count is visible at most four clocks after the input changes.
- R4: In mode 5 (step/direction), only a rising edge of X counts. The count goes up when Y is 1 and down when Y is 0. A falling X edge and any Y edge change nothing.
- R5: In mode 7 (half quadrature), only a Y edge counts, with the same direction rule as R3. An X edge alone changes nothing.
- R6: In modes 4 and 7, if X and Y both change within one synchronized sample, the event is discarded and the count holds.
- R7: Any other mode value, such as 6 or 9, stops the channel: its count holds whatever the inputs do.
- R8: An up-count while the count equals the ceiling gives 0. A down-count from 0 gives the ceiling value.
- R9: Status bit 7 is 1 after an up-count and 0 after a down-count of that channel. All other status bits read 0.
- R10: With shared bit 0 set, address 3 reads and writes the 32-bit count {count2, count1}, address 5 reads and writes the 32-bit ceiling {ceiling2, ceiling1}, and the joined counter follows channel 1's mode and inputs, carrying and borrowing across the 16-bit halves.
- R11: Channel 1 always decodes inputs A (X) and B (Y). Channel 2 decodes A/B when shared bit 1 is 0, and C (X) / D (Y) when it is 1.
- R12: A software write to a count register in the same cycle as a count event on that channel wins; the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A (pair 1, X) |
| enc_b | input | 1 | Encoder phase B (pair 1, Y) |
| enc_c | input | 1 | Encoder phase C (pair 2, X) |
| enc_d | input | 1 | Encoder phase D (pair 2, Y) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data at addr |

## Verification
The hardest case to reach is a software count write that lands in exactly the same cycle as a decoded edge. The edge only reaches the counter after the synchronizer and the previous-sample register. The bench changes phase A on a falling clock edge and waits two more falling edges. It then raises the write strobe for the next rising edge, the one where the decoded step is live. Double-phase changes are made by driving both inputs on one falling edge, so that both land in the same synchronized sample.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam logic [3:0] MODE_QUAD4    = 4'd4;
    localparam logic [3:0] MODE_STEP_DIR = 4'd5;
    localparam logic [3:0] MODE_QUAD2_Y  = 4'd7;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    typedef enum logic [3:0] {
        REG_MODE1  = 4'd0,
        REG_MODE2  = 4'd1,
        REG_SHARED = 4'd2,
        REG_CNT1   = 4'd3,
        REG_CNT2   = 4'd4,
        REG_CEIL1  = 4'd5,
        REG_CEIL2  = 4'd6,
        REG_STAT1  = 4'd7,
        REG_STAT2  = 4'd8
    } reg_addr_e;

    function automatic logic mode_counts(input logic [3:0] m);
        return (m == MODE_QUAD4) || (m == MODE_STEP_DIR) || (m == MODE_QUAD2_Y);
    endfunction
endpackage

// File: rtl/pcu_sync.sv
module pcu_sync #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prv
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw;
        st_d.s2   = st_q.s1;
        st_d.last = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.s2;
    assign prv = st_q.last;
endmodule

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       x_now,
    input  logic       y_now,
    input  logic       x_was,
    input  logic       y_was,
    output step_t      step
);
    logic x_edge, y_edge, differ;

    always_comb begin
        x_edge = x_now ^ x_was;
        y_edge = y_now ^ y_was;
        differ = x_now ^ y_now;
        step   = '0;
        case (mode)
            MODE_QUAD4: begin
                if (x_edge && !y_edge) begin
                    step.up = differ;
                    step.dn = !differ;
                end else if (y_edge && !x_edge) begin
                    step.up = !differ;
                    step.dn = differ;
                end
            end
            MODE_STEP_DIR: begin
                if (x_edge && x_now) begin
                    step.up = y_now;
                    step.dn = !y_now;
                end
            end
            MODE_QUAD2_Y: begin
                if (y_edge && !x_edge) begin
                    step.up = !differ;
                    step.dn = differ;
                end
            end
            default: step = '0;
        endcase
    end
endmodule

// File: rtl/phase_count_unit.sv
module phase_count_unit
    import pcu_pkg::*;
#(
    parameter int unsigned CW = 16,
    parameter int unsigned AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enc_a,
    input  logic            enc_b,
    input  logic            enc_c,
    input  logic            enc_d,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [2*CW-1:0] wdata,
    output logic [2*CW-1:0] rdata
);
    localparam int unsigned DW  = 2 * CW;
    localparam int unsigned NCH = 2;

    typedef struct packed {
        logic [NCH-1:0][3:0]    mode;
        logic                   join_en;
        logic                   pair_sel;
        logic [NCH-1:0][CW-1:0] cnt;
        logic [NCH-1:0][CW-1:0] ceil;
        logic [NCH-1:0]         dir;
    } state_t;

    state_t st_d, st_q;

    logic [3:0]     lvl, prv;
    logic [NCH-1:0] xn, yn, xw, yw;
    step_t          step [NCH];
    logic [DW-1:0]  wide_cnt, wide_ceil, wide_nxt;
    logic [DW-1:0]  ch_nxt [NCH];
    logic           wr_cnt1;

    function automatic logic [DW-1:0] bump(input logic [DW-1:0] v,
                                           input logic [DW-1:0] lim,
                                           input logic          up);
        if (up) return (v == lim) ? '0 : v + 1'b1;
        return (v == '0) ? lim : v - 1'b1;
    endfunction

    pcu_sync #(.N(4)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .raw({enc_d, enc_c, enc_b, enc_a}),
        .lvl(lvl), .prv(prv)
    );

    assign xn[0] = lvl[0];
    assign yn[0] = lvl[1];
    assign xw[0] = prv[0];
    assign yw[0] = prv[1];
    assign xn[1] = st_q.pair_sel ? lvl[2] : lvl[0];
    assign yn[1] = st_q.pair_sel ? lvl[3] : lvl[1];
    assign xw[1] = st_q.pair_sel ? prv[2] : prv[0];
    assign yw[1] = st_q.pair_sel ? prv[3] : prv[1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pcu_decode u_dec (
            .mode(st_q.mode[ch]),
            .x_now(xn[ch]), .y_now(yn[ch]),
            .x_was(xw[ch]), .y_was(yw[ch]),
            .step(step[ch])
        );
        assign ch_nxt[ch] = bump({{CW{1'b0}}, st_q.cnt[ch]},
                                 {{CW{1'b0}}, st_q.ceil[ch]}, step[ch].up);
    end

    assign wide_cnt  = {st_q.cnt[1], st_q.cnt[0]};
    assign wide_ceil = {st_q.ceil[1], st_q.ceil[0]};
    assign wide_nxt  = bump(wide_cnt, wide_ceil, step[0].up);
    assign wr_cnt1   = wr_en && (addr == AW'(REG_CNT1));

    always_comb begin
        st_d = st_q;
        if (st_q.join_en) begin
            if (step[0].up || step[0].dn) begin
                {st_d.cnt[1], st_d.cnt[0]} = wide_nxt;
                st_d.dir[0] = step[0].up;
            end
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (step[ch].up || step[ch].dn) begin
                    st_d.cnt[ch] = ch_nxt[ch][CW-1:0];
                    st_d.dir[ch] = step[ch].up;
                end
            end
        end
        if (wr_en) begin
            case (addr)
                AW'(REG_MODE1):  st_d.mode[0] = wdata[3:0];
                AW'(REG_MODE2):  st_d.mode[1] = wdata[3:0];
                AW'(REG_SHARED): {st_d.pair_sel, st_d.join_en} = wdata[1:0];
                AW'(REG_CNT1): begin
                    if (st_q.join_en) {st_d.cnt[1], st_d.cnt[0]} = wdata;
                    else              st_d.cnt[0] = wdata[CW-1:0];
                end
                AW'(REG_CNT2):   st_d.cnt[1] = wdata[CW-1:0];
                AW'(REG_CEIL1): begin
                    if (st_q.join_en) {st_d.ceil[1], st_d.ceil[0]} = wdata;
                    else              st_d.ceil[0] = wdata[CW-1:0];
                end
                AW'(REG_CEIL2):  st_d.ceil[1] = wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode[0]  <= MODE_QUAD4;
            st_q.mode[1]  <= MODE_QUAD4;
            st_q.ceil     <= '1;
            st_q.dir      <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(REG_MODE1):  rdata[3:0] = st_q.mode[0];
            AW'(REG_MODE2):  rdata[3:0] = st_q.mode[1];
            AW'(REG_SHARED): rdata[1:0] = {st_q.pair_sel, st_q.join_en};
            AW'(REG_CNT1):   rdata = st_q.join_en ? wide_cnt : {{CW{1'b0}}, st_q.cnt[0]};
            AW'(REG_CNT2):   rdata[CW-1:0] = st_q.cnt[1];
            AW'(REG_CEIL1):  rdata = st_q.join_en ? wide_ceil : {{CW{1'b0}}, st_q.ceil[0]};
            AW'(REG_CEIL2):  rdata[CW-1:0] = st_q.ceil[1];
            AW'(REG_STAT1):  rdata[7] = st_q.dir[0];
            AW'(REG_STAT2):  rdata[7] = st_q.dir[1];
            default: ;
        endcase
    end

    // R12: a count write beats a same-cycle count event
    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt1 && !st_q.join_en) |=> (st_q.cnt[0] == $past(wdata[CW-1:0])));

    // R8: up-count at the ceiling clears the count
    a_r8_ceiling_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.join_en && step[0].up && st_q.cnt[0] == st_q.ceil[0] && !wr_cnt1)
        |=> (st_q.cnt[0] == '0));

    // R8: down-count from zero reloads the ceiling
    a_r8_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.join_en && step[0].dn && st_q.cnt[0] == '0 && !wr_cnt1)
        |=> (st_q.cnt[0] == $past(st_q.ceil[0])));

    // R9: an up event leaves the direction flag set
    a_r9_dir_up: assert property (@(posedge clk) disable iff (!rst_n)
        step[0].up |=> st_q.dir[0]);

    // R7: a non-counting mode freezes channel 1
    a_r7_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.join_en && !mode_counts(st_q.mode[0]) && !wr_cnt1) |=> $stable(st_q.cnt[0]));

    // R10: joined counter carries from the low half into the high half
    a_r10_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.join_en && step[0].up && st_q.cnt[0] == '1 && wide_cnt != wide_ceil && !wr_cnt1)
        |=> (st_q.cnt[1] == $past(st_q.cnt[1]) + 1'b1));

    // R3: a decoder never asks for both directions
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step[0].up, step[0].dn, 1'b0}) && $onehot0({step[1].up, step[1].dn}));
endmodule

// File: tb/tb_phase_count_unit.sv
`timescale 1ns/1ps
module tb_phase_count_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_c = 1'b0, enc_d = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_MODE1 = 4'd0, A_MODE2 = 4'd1, A_SHR = 4'd2,
                           A_CNT1 = 4'd3, A_CNT2 = 4'd4, A_CEIL1 = 4'd5,
                           A_CEIL2 = 4'd6, A_STAT1 = 4'd7, A_STAT2 = 4'd8;

    phase_count_unit dut (
        .clk(clk), .rst_n(rst_n),
        .enc_a(enc_a), .enc_b(enc_b), .enc_c(enc_c), .enc_d(enc_d),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=0x%08h expected=0x%08h", req, a, rdata, exp);
        end
    endtask

    task automatic drive(input logic a, input logic b, input logic c, input logic d);
        @(negedge clk);
        enc_a = a; enc_b = b; enc_c = c; enc_d = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        expect_reg("R1", A_CNT1, 32'd0);
        expect_reg("R1", A_CNT2, 32'd0);
        expect_reg("R1", A_CEIL1, 32'h0000FFFF);
        expect_reg("R1", A_CEIL2, 32'h0000FFFF);
        expect_reg("R1", A_MODE1, 32'd4);
        expect_reg("R1", A_MODE2, 32'd4);
        expect_reg("R1", A_SHR, 32'd0);
        expect_reg("R1", A_STAT1, 32'h80);
        expect_reg("R1", A_STAT2, 32'h80);
    endtask

    task automatic t_regs;
        wr(A_MODE2, 32'h35);
        expect_reg("R2", A_MODE2, 32'd5);
        wr(A_MODE2, 32'd4);
        wr(A_CEIL2, 32'hABCD1234);
        expect_reg("R2", A_CEIL2, 32'h1234);
        wr(A_CEIL2, 32'hFFFF);
        wr(A_SHR, 32'hFFFF_FFFF);
        expect_reg("R2", A_SHR, 32'd3);
        wr(A_SHR, 32'd0);
        wr(A_STAT1, 32'd0);
        expect_reg("R2", A_STAT1, 32'h80);
    endtask

    task automatic t_x4;
        wr(A_CNT1, 32'd0);
        drive(1, 0, 0, 0);
        expect_reg("R3", A_CNT1, 32'd1);
        expect_reg("R9", A_STAT1, 32'h80);
        drive(1, 1, 0, 0);
        drive(0, 1, 0, 0);
        drive(0, 0, 0, 0);
        expect_reg("R3", A_CNT1, 32'd4);
        drive(0, 1, 0, 0);
        expect_reg("R3", A_CNT1, 32'd3);
        expect_reg("R9", A_STAT1, 32'h00);
        drive(1, 1, 0, 0);
        drive(1, 0, 0, 0);
        drive(0, 0, 0, 0);
        expect_reg("R3", A_CNT1, 32'd0);
    endtask

    task automatic t_invalid;
        wr(A_CNT1, 32'd5);
        drive(1, 1, 0, 0);
        expect_reg("R6", A_CNT1, 32'd5);
        drive(0, 0, 0, 0);
        expect_reg("R6", A_CNT1, 32'd5);
    endtask

    task automatic t_step_dir;
        wr(A_MODE1, 32'd5);
        wr(A_CNT1, 32'd10);
        drive(0, 1, 0, 0);
        expect_reg("R4", A_CNT1, 32'd10);
        drive(1, 1, 0, 0);
        expect_reg("R4", A_CNT1, 32'd11);
        drive(0, 1, 0, 0);
        drive(0, 0, 0, 0);
        expect_reg("R4", A_CNT1, 32'd11);
        drive(1, 0, 0, 0);
        expect_reg("R4", A_CNT1, 32'd10);
        expect_reg("R9", A_STAT1, 32'h00);
        drive(0, 0, 0, 0);
        expect_reg("R4", A_CNT1, 32'd10);
    endtask

    task automatic t_half;
        wr(A_MODE1, 32'd7);
        wr(A_CNT1, 32'd10);
        drive(1, 0, 0, 0);
        expect_reg("R5", A_CNT1, 32'd10);
        drive(1, 1, 0, 0);
        expect_reg("R5", A_CNT1, 32'd11);
        drive(0, 1, 0, 0);
        expect_reg("R5", A_CNT1, 32'd11);
        drive(0, 0, 0, 0);
        expect_reg("R5", A_CNT1, 32'd12);
        drive(0, 1, 0, 0);
        expect_reg("R5", A_CNT1, 32'd11);
        drive(1, 0, 0, 0);
        expect_reg("R6", A_CNT1, 32'd11);
        drive(0, 0, 0, 0);
        expect_reg("R5", A_CNT1, 32'd11);
    endtask

    task automatic t_reserved;
        wr(A_MODE1, 32'd6);
        wr(A_CNT1, 32'd20);
        drive(1, 0, 0, 0);
        drive(1, 1, 0, 0);
        drive(0, 1, 0, 0);
        drive(0, 0, 0, 0);
        expect_reg("R7", A_CNT1, 32'd20);
        wr(A_MODE1, 32'd9);
        drive(1, 0, 0, 0);
        drive(0, 0, 0, 0);
        expect_reg("R7", A_CNT1, 32'd20);
        wr(A_MODE1, 32'd4);
    endtask

    task automatic t_ceiling;
        wr(A_CEIL1, 32'd3);
        wr(A_CNT1, 32'd2);
        drive(1, 0, 0, 0);
        expect_reg("R8", A_CNT1, 32'd3);
        drive(1, 1, 0, 0);
        expect_reg("R8", A_CNT1, 32'd0);
        drive(1, 0, 0, 0);
        expect_reg("R8", A_CNT1, 32'd3);
        drive(0, 0, 0, 0);
        expect_reg("R8", A_CNT1, 32'd2);
        wr(A_CEIL1, 32'hFFFF);
    endtask

    task automatic t_join;
        wr(A_SHR, 32'd1);
        wr(A_CEIL1, 32'hFFFF_FFFF);
        expect_reg("R10", A_CEIL1, 32'hFFFF_FFFF);
        wr(A_CNT1, 32'h0000_FFFF);
        drive(1, 0, 0, 0);
        expect_reg("R10", A_CNT1, 32'h0001_0000);
        expect_reg("R10", A_CNT2, 32'h0000_0001);
        drive(1, 1, 0, 0);
        expect_reg("R10", A_CNT1, 32'h0001_0001);
        drive(1, 0, 0, 0);
        drive(0, 0, 0, 0);
        expect_reg("R10", A_CNT1, 32'h0000_FFFF);
        wr(A_CNT1, 32'd0);
        drive(0, 1, 0, 0);
        expect_reg("R10", A_CNT1, 32'hFFFF_FFFF);
        drive(0, 0, 0, 0);
        expect_reg("R10", A_CNT1, 32'd0);
        wr(A_SHR, 32'd0);
    endtask

    task automatic t_pair;
        wr(A_SHR, 32'd2);
        wr(A_CNT1, 32'd0);
        wr(A_CNT2, 32'd0);
        drive(0, 0, 1, 0);
        expect_reg("R11", A_CNT2, 32'd1);
        expect_reg("R11", A_CNT1, 32'd0);
        drive(1, 0, 1, 0);
        expect_reg("R11", A_CNT1, 32'd1);
        expect_reg("R11", A_CNT2, 32'd1);
        drive(0, 0, 0, 0);
        expect_reg("R11", A_CNT2, 32'd0);
        wr(A_SHR, 32'd0);
        drive(1, 0, 0, 0);
        expect_reg("R11", A_CNT2, 32'd1);
        drive(0, 0, 0, 0);
        drive(0, 0, 1, 0);
        expect_reg("R11", A_CNT2, 32'd0);
        drive(0, 0, 0, 0);
    endtask

    task automatic t_priority;
        wr(A_CNT1, 32'd7);
        @(negedge clk);
        enc_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = A_CNT1; wdata = 32'd100;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        expect_reg("R12", A_CNT1, 32'd100);
        drive(0, 0, 0, 0);
        expect_reg("R12", A_CNT1, 32'd99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_x4();
        t_invalid();
        t_step_dir();
        t_half();
        t_reserved();
        t_ceiling();
        t_join();
        t_pair();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule